// File: doc/BRIEF.md
# Interrupt arbitration and vectoring unit

This unit sits next to a small 8-bit processor core and decides when the core leaves its instruction stream to run a service routine. It gates the raw hardware request flags with their own enable bits and with the core's global interrupt mask. It waits for the instruction in progress to finish. It then holds the core in a stacking step and tells the core to set the mask. Only after that does it pick a winner and hand out the two addresses from which the routine's start address is read.

Some sources share a vector slot. The timer overflow and real-time flags both request the core-timer slot, and the external pin and every keyscan line request the external slot. Among the slots, the higher vector address always wins. A software interrupt instruction is accepted even when the mask is set. A reset request overrides any sequence in progress and goes directly to the reset vector fetch, with no stacking step. The unit never clears a source flag. A request that is still asserted when the routine ends and the mask clears is serviced again.

Top module: `irq_vector_unit`

## Requirements
- R1: In idle, a service sequence starts (take_irq rises on the next cycle) only in a cycle where instr_done is high; with instr_done low, no request is taken.
- R2: A hardware source counts only when its src_flag and src_en bits are both 1 and i_bit is 0. A request that is masked by i_bit stays pending and is taken at the first completed instruction after i_bit returns to 0.
- R3: take_irq stays high until stack_done. set_i is high during the stack_done cycle. The first vector address appears two cycles after that stack_done cycle.
- R4: Arbitration is done after stacking, over the requests present at that moment. The priority order is software interrupt, then external, then end-of-cycle, then core timer.
- R5: With the default top VEC_TOP=0x3FFE, the high-byte fetch addresses are: reset 0x3FFE, software interrupt 0x3FFC, external 0x3FFA, end-of-cycle 0x3FF8, core timer 0x3FF6.
- R6: swi_req together with instr_done starts a sequence that vectors to 0x3FFC, even when i_bit is 1 and hardware requests are pending.
- R7: Flag bit positions are: bit 0 timer overflow and bit 1 real-time (both core-timer slot), bit 2 end-of-cycle, bit 3 external pin, and bits 4 and up keyscan lines (external slot).
- R8: rst_req in any state puts address 0x3FFE on vec_addr, with vec_valid high and take_irq low, in the next cycle.
- R9: The vector is read as two bytes. The first address is the slot address and is held until fetch_done. The second address is the slot address plus one. fetch_done on the second byte drops vec_valid.
- R10: Source flags that are still set after a routine ends are taken again once i_bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_flag | input | KEY_W+4 | Raw request flags of the hardware sources |
| src_en | input | KEY_W+4 | Per-source enable bits |
| i_bit | input | 1 | Global interrupt mask from the core |
| instr_done | input | 1 | Strobe: the current instruction has completed |
| swi_req | input | 1 | The completing instruction is a software interrupt |
| rst_req | input | 1 | Reset vector request |
| stack_done | input | 1 | Core has finished stacking its registers |
| fetch_done | input | 1 | The current vector byte has been read |
| take_irq | output | 1 | Request to the core to stack registers |
| set_i | output | 1 | Command to set the mask bit |
| vec_valid | output | 1 | A vector address is being presented |
| vec_addr | output | 16 | Vector byte address |

## Verification
The bench builds the unit with KEY_W=2, which gives six source flags. This makes every combination of flags and enables reachable: 4096 cases, each run through a full sequence, with the expected slot worked out from the bit-to-slot mapping. Smaller sweeps cover a set mask with later release, software interrupts under a set mask, reset requests in the middle of a sequence, and back-to-back retakes of flags that were never cleared.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
  localparam int ADDR_W = 16;
  localparam int NSLOT  = 5;
  localparam int SLOT_W = $clog2(NSLOT);

  // Slot index doubles as priority (0 highest) and vector offset (x2 below top)
  localparam logic [SLOT_W-1:0] SLOT_RESET = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_SWI   = 3'd1;
  localparam logic [SLOT_W-1:0] SLOT_EXT   = 3'd2;
  localparam logic [SLOT_W-1:0] SLOT_EOC   = 3'd3;
  localparam logic [SLOT_W-1:0] SLOT_TMR   = 3'd4;

  // Flag bit positions
  localparam int FB_TOVF = 0;
  localparam int FB_RTI  = 1;
  localparam int FB_EOC  = 2;
  localparam int FB_PIN  = 3;
  localparam int FB_KEY0 = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_STACK = 3'd1,
    ST_ARB   = 3'd2,
    ST_VHI   = 3'd3,
    ST_VLO   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/ivu_req_merge.sv
module ivu_req_merge
  import ivu_pkg::*;
#(
  parameter int KEY_W = 4,
  localparam int NSRC = FB_KEY0 + KEY_W
) (
  input  logic [NSRC-1:0]  flag,
  input  logic [NSRC-1:0]  en,
  output logic [NSLOT-1:0] hw_req,
  output logic             hw_any
);
  logic [KEY_W-1:0] key_hit;

  generate
    for (genvar k = 0; k < KEY_W; k++) begin : g_key
      assign key_hit[k] = flag[FB_KEY0+k] & en[FB_KEY0+k];
    end
  endgenerate

  always_comb begin
    hw_req = '0;
    hw_req[SLOT_EXT] = (flag[FB_PIN] & en[FB_PIN]) | (|key_hit);
    hw_req[SLOT_EOC] = flag[FB_EOC] & en[FB_EOC];
    hw_req[SLOT_TMR] = (flag[FB_TOVF] & en[FB_TOVF]) | (flag[FB_RTI] & en[FB_RTI]);
  end

  assign hw_any = |hw_req;
endmodule

// File: rtl/ivu_prio_pick.sv
module ivu_prio_pick #(
  parameter int N = 5,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] idx,
  output logic         any
);
  // Lowest index wins: scan from the bottom of the priority list upward
  always_comb begin
    idx = W'(N - 1);
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/ivu_seq.sv
module ivu_seq
  import ivu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_bit,
  input  logic              instr_done,
  input  logic              swi_req,
  input  logic              rst_req,
  input  logic              stack_done,
  input  logic              fetch_done,
  input  logic              hw_any,
  input  logic [SLOT_W-1:0] pick_idx,
  input  logic              pick_any,
  output logic              swi_pend,
  output logic              take_irq,
  output logic              set_i,
  output logic              vec_valid,
  output logic              vec_lo,
  output logic [SLOT_W-1:0] slot
);
  seq_state_e        state_q, state_d;
  logic              swi_q, swi_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              start;

  assign start = instr_done & (swi_req | (~i_bit & hw_any));

  always_comb begin
    state_d = state_q;
    swi_d   = swi_q;
    slot_d  = slot_q;
    if (rst_req) begin
      state_d = ST_VHI;
      slot_d  = SLOT_RESET;
      swi_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_d = ST_STACK;
          swi_d   = swi_req;
        end
        ST_STACK: if (stack_done) state_d = ST_ARB;
        ST_ARB: begin
          state_d = ST_VHI;
          slot_d  = pick_any ? pick_idx : SLOT_TMR;
          swi_d   = 1'b0;
        end
        ST_VHI: if (fetch_done) state_d = ST_VLO;
        ST_VLO: if (fetch_done) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      swi_q   <= 1'b0;
      slot_q  <= SLOT_RESET;
    end else begin
      state_q <= state_d;
      swi_q   <= swi_d;
      slot_q  <= slot_d;
    end
  end

  assign swi_pend  = swi_q;
  assign take_irq  = (state_q == ST_STACK);
  assign set_i     = (state_q == ST_STACK) & stack_done & ~rst_req;
  assign vec_valid = (state_q == ST_VHI) | (state_q == ST_VLO);
  assign vec_lo    = (state_q == ST_VLO);
  assign slot      = slot_q;

  assert_start_on_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STACK && $past(state_q) == ST_IDLE) |-> $past(instr_done));

  assert_mask_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STACK && $past(state_q) == ST_IDLE) |-> $past(swi_req || (!i_bit && hw_any)));

  assert_arb_after_stack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARB) |-> ($past(state_q) == ST_STACK && $past(stack_done)));

  assert_swi_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VHI && $past(state_q) == ST_ARB && $past(swi_q)) |-> (slot_q == SLOT_SWI));

  assert_lo_after_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VLO && $past(state_q) != ST_VLO) |-> ($past(state_q) == ST_VHI && $past(fetch_done)));
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import ivu_pkg::*;
#(
  parameter int                KEY_W   = 4,
  parameter logic [ADDR_W-1:0] VEC_TOP = 16'h3FFE,
  localparam int NSRC = FB_KEY0 + KEY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_flag,
  input  logic [NSRC-1:0]   src_en,
  input  logic              i_bit,
  input  logic              instr_done,
  input  logic              swi_req,
  input  logic              rst_req,
  input  logic              stack_done,
  input  logic              fetch_done,
  output logic              take_irq,
  output logic              set_i,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [NSLOT-1:0]  hw_req;
  logic [NSLOT-1:0]  arb_req;
  logic              hw_any;
  logic [SLOT_W-1:0] pick_idx;
  logic              pick_any;
  logic              swi_pend;
  logic              vec_lo;
  logic [SLOT_W-1:0] slot;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ivu_req_merge #(.KEY_W(KEY_W)) u_merge (
    .flag   (src_flag),
    .en     (src_en),
    .hw_req (hw_req),
    .hw_any (hw_any)
  );

  always_comb begin
    arb_req = hw_req;
    arb_req[SLOT_SWI] = swi_pend;
  end

  ivu_prio_pick #(.N(NSLOT)) u_pick (
    .req (arb_req),
    .idx (pick_idx),
    .any (pick_any)
  );

  ivu_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .i_bit      (i_bit),
    .instr_done (instr_done),
    .swi_req    (swi_req),
    .rst_req    (rst_req),
    .stack_done (stack_done),
    .fetch_done (fetch_done),
    .hw_any     (hw_any),
    .pick_idx   (pick_idx),
    .pick_any   (pick_any),
    .swi_pend   (swi_pend),
    .take_irq   (take_irq),
    .set_i      (set_i),
    .vec_valid  (vec_valid),
    .vec_lo     (vec_lo),
    .slot       (slot)
  );

  always_comb begin
    vec_addr = VEC_TOP - {{(ADDR_W-SLOT_W-1){1'b0}}, slot, 1'b0};
    if (vec_lo) vec_addr = vec_addr + ADDR_W'(1);
  end

  assert_reset_vector_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(rst_req) && $past(rst_int_n)) |-> (vec_valid && !take_irq && vec_addr == VEC_TOP));

  assert_addr_window_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    vec_valid |-> (vec_addr <= VEC_TOP + ADDR_W'(1) && vec_addr >= VEC_TOP - ADDR_W'(2*(NSLOT-1))));

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(take_irq && vec_valid));
endmodule

// File: tb/tb_irq_vector_unit.sv
module tb_irq_vector_unit;
  localparam int KEY_W = 2;
  localparam int NSRC  = 4 + KEY_W;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] src_flag, src_en;
  logic            i_bit, instr_done, swi_req, rst_req, stack_done, fetch_done;
  logic            take_irq, set_i, vec_valid;
  logic [15:0]     vec_addr;
  int              checks = 0;
  int              fails  = 0;
  bit              done   = 1'b0;

  always #10 clk = ~clk;

  irq_vector_unit #(.KEY_W(KEY_W), .VEC_TOP(16'h3FFE)) dut (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en), .i_bit(i_bit),
    .instr_done(instr_done), .swi_req(swi_req), .rst_req(rst_req),
    .stack_done(stack_done), .fetch_done(fetch_done), .take_irq(take_irq),
    .set_i(set_i), .vec_valid(vec_valid), .vec_addr(vec_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected slot from the flag map (R7): -1 means no hardware request
  function automatic int exp_slot(input logic [NSRC-1:0] f, input logic [NSRC-1:0] e);
    logic [NSRC-1:0] g;
    g = f & e;
    if (g[3] || (|g[NSRC-1:4])) return 2;
    if (g[2]) return 3;
    if (g[0] || g[1]) return 4;
    return -1;
  endfunction

  function automatic logic [15:0] slot_addr(input int s);
    return 16'h3FFE - 16'(2 * s);
  endfunction

  // One full pass starting with an instruction completion
  task automatic service(input bit swi, input bit exp_take, input logic [15:0] exp_addr, input string req);
    @(negedge clk);
    instr_done = 1'b1;
    swi_req    = swi;
    @(negedge clk);
    instr_done = 1'b0;
    swi_req    = 1'b0;
    chk(take_irq == exp_take, {req, " R1 take"}, 32'(take_irq), 32'(exp_take));
    if (!exp_take) begin
      chk(!vec_valid, {req, " R2 idle"}, 32'(vec_valid), 0);
      return;
    end
    chk(!set_i, "R3 set_i early", 32'(set_i), 0);
    @(negedge clk);
    chk(take_irq, "R3 hold", 32'(take_irq), 1);
    stack_done = 1'b1;
    #1;
    chk(set_i, "R3 set_i", 32'(set_i), 1);
    @(negedge clk);
    stack_done = 1'b0;
    i_bit      = 1'b1;
    chk(!vec_valid && !take_irq, "R3 arb gap", 32'(vec_valid), 0);
    @(negedge clk);
    chk(vec_valid && vec_addr == exp_addr, {req, " R5 hi"}, 32'(vec_addr), 32'(exp_addr));
    @(negedge clk);
    chk(vec_addr == exp_addr, "R9 hi held", 32'(vec_addr), 32'(exp_addr));
    fetch_done = 1'b1;
    @(negedge clk);
    fetch_done = 1'b0;
    chk(vec_valid && vec_addr == exp_addr + 16'd1, "R9 lo", 32'(vec_addr), 32'(exp_addr + 16'd1));
    fetch_done = 1'b1;
    @(negedge clk);
    fetch_done = 1'b0;
    chk(!vec_valid, "R9 end", 32'(vec_valid), 0);
    i_bit = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; src_flag = '0; src_en = '0; i_bit = 1'b0; instr_done = 1'b0;
    swi_req = 1'b0; rst_req = 1'b0; stack_done = 1'b0; fetch_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!take_irq && !vec_valid && !set_i, "reset state", 32'({take_irq, vec_valid, set_i}), 0);

    // R1: pending request, no completion strobe
    src_flag = '1; src_en = '1;
    repeat (4) @(negedge clk);
    chk(!take_irq, "R1 no strobe", 32'(take_irq), 0);

    // R2 R4 R5 R7: exhaustive flags x enables
    for (int f = 0; f < (1 << NSRC); f++) begin
      for (int e = 0; e < (1 << NSRC); e++) begin
        int s;
        src_flag = NSRC'(f);
        src_en   = NSRC'(e);
        s = exp_slot(src_flag, src_en);
        service(1'b0, s >= 0, (s >= 0) ? slot_addr(s) : 16'h0, "R4 sweep");
      end
    end

    // R2: masked requests stay pending, taken after i_bit clears
    src_en = '1;
    for (int f = 1; f < (1 << NSRC); f++) begin
      src_flag = NSRC'(f);
      i_bit = 1'b1;
      service(1'b0, 1'b0, 16'h0, "R2 masked");
      i_bit = 1'b0;
      service(1'b0, 1'b1, slot_addr(exp_slot(src_flag, src_en)), "R2 released");
    end

    // R6: software interrupt ignores mask, beats hardware
    for (int f = 0; f < (1 << NSRC); f += 7) begin
      src_flag = NSRC'(f);
      i_bit = 1'b1;
      service(1'b1, 1'b1, 16'h3FFC, "R6 swi masked");
    end

    // R10: uncleared flag is retaken
    src_flag = NSRC'(1 << 2);
    service(1'b0, 1'b1, 16'h3FF8, "R10 first");
    service(1'b0, 1'b1, 16'h3FF8, "R10 again");

    // R8: reset request from idle and mid-sequence
    src_flag = '0;
    @(negedge clk);
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    chk(vec_valid && vec_addr == 16'h3FFE, "R8 idle", 32'(vec_addr), 32'h3FFE);
    fetch_done = 1'b1;
    @(negedge clk);
    chk(vec_addr == 16'h3FFF, "R8 lo", 32'(vec_addr), 32'h3FFF);
    @(negedge clk);
    fetch_done = 1'b0;
    src_flag = NSRC'(1);
    instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
    chk(take_irq, "R8 pre", 32'(take_irq), 1);
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    chk(vec_valid && !take_irq && vec_addr == 16'h3FFE, "R8 mid", 32'(vec_addr), 32'h3FFE);
    fetch_done = 1'b1;
    repeat (2) @(negedge clk);
    fetch_done = 1'b0;
    chk(!vec_valid, "R9 reset end", 32'(vec_valid), 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule